// File: doc/BRIEF.md
# Oversampling Clock and Frame Generator

This block turns a master clock into the two timing references a sigma-delta converter pair and its serial port need: an oversampling clock, which doubles as the serial shift clock, and a sample-rate frame. It runs entirely in the master-clock domain. The oversampling clock is delivered as a one-cycle enable (`oclkTick`), so downstream logic stays on the same clock tree. The enable comes from two cascaded programmable dividers, M and then Q. A bypass input skips both dividers when the master clock already runs at the oversampling rate. A frame counter then divides the ticks by a selectable oversampling ratio.

As frame master, the block closes each frame by itself once the ratio's worth of ticks has been consumed. In slave mode the host owns the frame phase. Each falling edge of the external frame sync restarts the prescaler and the frame counter, and the block pulses an error when the host's frame did not span exactly one ratio of ticks. Divider, ratio and bypass settings are captured only at a frame boundary, so a frame never mixes two settings.

Top module: `ovsClkFrameGen`

## Requirements
- R1: Synchronous reset (`rst` high) clears `sampleStrobe` and `syncErr` and holds `frameSync` high. The active setting after reset is ratio 160 with both dividers at one, so the first `sampleStrobe` comes 160 master cycles after reset is released, with 160 ticks in that frame.
- R2: With `bypassDiv` low, `oclkTick` pulses once every M×Q master cycles, where M and Q are the captured `mDivIn` and `qDivIn` values. A code of 0 divides by 1.
- R3: With `bypassDiv` captured high, `oclkTick` is high on every master cycle.
- R4: `ratioSel` codes 0, 1, 2, 3 and 4 select ratios 64, 96, 128, 160 and 192. Codes 5 to 7 select 160.
- R5: As master (`slaveMode` low), one frame consumes exactly ratio ticks. `sampleStrobe` is a single-cycle pulse in the cycle after the edge that closes the frame, so a frame lasts M×Q×ratio master cycles.
- R6: `frameSync` is high from a frame boundary until the first tick of the new frame is consumed, and low for the rest of the frame.
- R7: Changes on `bypassDiv`, `mDivIn`, `qDivIn` and `ratioSel` are captured only at a frame boundary. The frame already running keeps its setting.
- R8: As master, toggling `extFs` has no effect on frame timing.
- R9: In slave mode the internal wrap is disabled. A falling edge of `extFs` (high in one sampled cycle, low in the next) ends the frame. `sampleStrobe` follows one cycle later, and the prescaler and frame count restart from zero.
- R10: In slave mode a falling `extFs` edge raises a one-cycle `syncErr`, coincident with its `sampleStrobe`, when the ticks consumed since the previous falling edge differ from the ratio. The first edge after entering slave mode never flags, and `syncErr` is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| bypassDiv | input | 1 | Master clock equals oversampling clock; skip M and Q |
| slaveMode | input | 1 | Frame phase taken from `extFs` |
| mDivIn | input | 4 | First prescaler divide value |
| qDivIn | input | 4 | Second prescaler divide value |
| ratioSel | input | 3 | Oversampling ratio code |
| extFs | input | 1 | Host frame sync, used in slave mode |
| oclkTick | output | 1 | Oversampling/shift clock enable |
| frameSync | output | 1 | High during the first tick period of a frame |
| sampleStrobe | output | 1 | One-cycle pulse per frame boundary |
| syncErr | output | 1 | Pulse on a mis-spaced host frame edge |

## Verification
The master frame period is measured with several settings: a pure M×Q division, a Q-only division with M at code 0, a bypassed prescaler at ratio 192, an out-of-range ratio code and a three-way division. Together these separate the prescaler product, the bypass path and the ratio decoding. The setting is changed one frame ahead of its capture, which separates immediate from boundary-aligned take-up. The host frame sync is toggled during master operation to show it is ignored. In slave mode the host spaces its edges at exactly one ratio, at one tick too many and at one tick too few. This tells apart correct edges, flagged edges and the realignment that lets the following correct frame pass clean.

// File: rtl/ovsGenPkg.sv
package ovsGenPkg;
  parameter int M_W        = 4;
  parameter int Q_W        = 4;
  parameter int SEL_W      = 3;
  parameter int RATIO_UNIT = 32;
  parameter int SEL_COUNT  = 5;
  parameter int DEF_SEL    = 3;

  localparam int MAX_RATIO = (SEL_COUNT + 1) * RATIO_UNIT;
  localparam int CNT_W     = $clog2(MAX_RATIO + 1);

  typedef struct packed {
    logic             bypass;
    logic [SEL_W-1:0] ratioSel;
    logic [M_W-1:0]   mDiv;
    logic [Q_W-1:0]   qDiv;
  } genCfg_t;

  typedef struct packed {
    logic restart;
  } ctrlStb_t;

  localparam genCfg_t DEF_CFG = '{
    bypass:   1'b0,
    ratioSel: SEL_W'(DEF_SEL),
    mDiv:     M_W'(1),
    qDiv:     Q_W'(1)
  };

  function automatic logic [CNT_W-1:0] ratioOf(input logic [SEL_W-1:0] sel);
    if (int'(sel) < SEL_COUNT)
      return CNT_W'((int'(sel) + 2) * RATIO_UNIT);
    else
      return CNT_W'((DEF_SEL + 2) * RATIO_UNIT);
  endfunction
endpackage

// File: rtl/ovsDivPath.sv
module ovsDivPath
  import ovsGenPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bypass,
  input  logic [M_W-1:0]   mDiv,
  input  logic [Q_W-1:0]   qDiv,
  input  ctrlStb_t         stb,
  output logic             tick,
  output logic [CNT_W-1:0] frameCnt
);
  logic [M_W-1:0] mCnt;
  logic [Q_W-1:0] qCnt;
  logic [M_W-1:0] mLast;
  logic [Q_W-1:0] qLast;
  logic           mWrap;
  logic           qWrap;

  // a divide code of zero behaves as divide-by-one
  always_comb begin
    mLast = (mDiv == '0) ? '0 : mDiv - M_W'(1);
    qLast = (qDiv == '0) ? '0 : qDiv - Q_W'(1);
    mWrap = (mCnt == mLast);
    qWrap = mWrap && (qCnt == qLast);
    tick  = bypass || qWrap;
  end

  always_ff @(posedge clk) begin
    if (rst || stb.restart) begin
      mCnt <= '0;
      qCnt <= '0;
    end else begin
      mCnt <= mWrap ? '0 : mCnt + M_W'(1);
      if (mWrap) qCnt <= qWrap ? '0 : qCnt + Q_W'(1);
    end
  end

  // ticks consumed in the current frame, saturating
  always_ff @(posedge clk) begin
    if (rst || stb.restart) frameCnt <= '0;
    else if (tick && (frameCnt != '1)) frameCnt <= frameCnt + CNT_W'(1);
  end
endmodule

// File: rtl/ovsFrameCtrl.sv
module ovsFrameCtrl
  import ovsGenPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             slaveMode,
  input  logic             extFs,
  input  genCfg_t          cfgIn,
  input  logic             tick,
  input  logic [CNT_W-1:0] frameCnt,
  output genCfg_t          cfgCur,
  output ctrlStb_t         stb,
  output logic             frameSync,
  output logic             sampleStrobe,
  output logic             syncErr
);
  logic             fsPrev;
  logic             haveRef;
  logic             fsFall;
  logic             masterEnd;
  logic             boundary;
  logic [CNT_W-1:0] ratio;
  logic [CNT_W:0]   seenTotal;

  always_comb begin
    ratio       = ratioOf(cfgCur.ratioSel);
    masterEnd   = !slaveMode && tick && (frameCnt >= ratio - CNT_W'(1));
    fsFall      = slaveMode && fsPrev && !extFs;
    boundary    = masterEnd || fsFall;
    seenTotal   = {1'b0, frameCnt} + {{CNT_W{1'b0}}, tick};
    stb.restart = boundary;
    frameSync   = (frameCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgCur       <= DEF_CFG;
      fsPrev       <= 1'b0;
      haveRef      <= 1'b0;
      sampleStrobe <= 1'b0;
      syncErr      <= 1'b0;
    end else begin
      fsPrev       <= extFs;
      sampleStrobe <= boundary;
      syncErr      <= fsFall && haveRef && (seenTotal != {1'b0, ratio});
      if (boundary) cfgCur <= cfgIn;
      if (!slaveMode) haveRef <= 1'b0;
      else if (fsFall) haveRef <= 1'b1;
    end
  end
endmodule

// File: rtl/ovsClkFrameGen.sv
module ovsClkFrameGen
  import ovsGenPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bypassDiv,
  input  logic             slaveMode,
  input  logic [M_W-1:0]   mDivIn,
  input  logic [Q_W-1:0]   qDivIn,
  input  logic [SEL_W-1:0] ratioSel,
  input  logic             extFs,
  output logic             oclkTick,
  output logic             frameSync,
  output logic             sampleStrobe,
  output logic             syncErr
);
  genCfg_t          cfgIn;
  genCfg_t          cfgCur;
  ctrlStb_t         stb;
  logic [CNT_W-1:0] frameCnt;

  assign cfgIn = '{bypass: bypassDiv, ratioSel: ratioSel, mDiv: mDivIn, qDiv: qDivIn};

  ovsFrameCtrl uCtrl (
    .clk(clk), .rst(rst), .slaveMode(slaveMode), .extFs(extFs),
    .cfgIn(cfgIn), .tick(oclkTick), .frameCnt(frameCnt),
    .cfgCur(cfgCur), .stb(stb), .frameSync(frameSync),
    .sampleStrobe(sampleStrobe), .syncErr(syncErr)
  );

  ovsDivPath uPath (
    .clk(clk), .rst(rst), .bypass(cfgCur.bypass), .mDiv(cfgCur.mDiv),
    .qDiv(cfgCur.qDiv), .stb(stb), .tick(oclkTick), .frameCnt(frameCnt)
  );
endmodule

// File: rtl/ovsGenChk.sv
module ovsGenChk
  import ovsGenPkg::*;
(
  input logic    clk,
  input logic    rst,
  input logic    slaveMode,
  input logic    oclkTick,
  input logic    frameSync,
  input logic    sampleStrobe,
  input logic    syncErr,
  input genCfg_t cfgCur
);
  // R6
  strobe_fs_chk: assert property (@(posedge clk) disable iff (rst)
    sampleStrobe |-> frameSync);

  // R5
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sampleStrobe |=> !sampleStrobe);

  // R10
  err_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    syncErr |-> (sampleStrobe && $past(slaveMode)));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sampleStrobe |-> $stable(cfgCur));

  // R3
  bypass_tick_chk: assert property (@(posedge clk) disable iff (rst)
    cfgCur.bypass |-> oclkTick);
endmodule

bind ovsClkFrameGen ovsGenChk uChk (
  .clk(clk), .rst(rst), .slaveMode(slaveMode), .oclkTick(oclkTick),
  .frameSync(frameSync), .sampleStrobe(sampleStrobe), .syncErr(syncErr),
  .cfgCur(cfgCur)
);

// File: tb/tb_ovsClkFrameGen.sv
module tb_ovsClkFrameGen;
  import ovsGenPkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst = 1'b1;
  logic             bypassDiv = 1'b0;
  logic             slaveMode = 1'b0;
  logic [M_W-1:0]   mDivIn = '0;
  logic [Q_W-1:0]   qDivIn = '0;
  logic [SEL_W-1:0] ratioSel = '0;
  logic             extFs = 1'b0;
  logic             oclkTick, frameSync, sampleStrobe, syncErr;

  ovsClkFrameGen dut (
    .clk(clk), .rst(rst), .bypassDiv(bypassDiv), .slaveMode(slaveMode),
    .mDivIn(mDivIn), .qDivIn(qDivIn), .ratioSel(ratioSel), .extFs(extFs),
    .oclkTick(oclkTick), .frameSync(frameSync), .sampleStrobe(sampleStrobe),
    .syncErr(syncErr)
  );

  typedef struct {
    int    len;
    int    ticks;
    bit    err;
    string tag;
  } frameExp_t;

  frameExp_t expQ[$];
  int  checks = 0;
  int  errors = 0;
  bit  running = 1'b0;
  bit  toggleOn = 1'b0;
  bit  done = 1'b0;
  int  negIdx = 0;
  int  lastIdx = 1;
  int  tickCnt = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic pushFrame(int len, int ticks, bit err, string tag);
    frameExp_t e;
    e.len = len; e.ticks = ticks; e.err = err; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic setCfg(bit byp, int m, int q, int sel);
    bypassDiv = byp;
    mDivIn    = M_W'(m);
    qDivIn    = Q_W'(q);
    ratioSel  = SEL_W'(sel);
  endtask

  task automatic waitStrobe();
    do @(negedge clk); while (!sampleStrobe);
  endtask

  task automatic slaveFrame(int p);
    @(negedge clk) extFs = 1'b1;
    repeat (p - 1) @(negedge clk);
    extFs = 1'b0;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: pops the expected frame at each strobe and compares
  always @(negedge clk) begin
    if (running && !done) begin
      negIdx++;
      if (sampleStrobe) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5", "unexpected strobe at sample", negIdx, 0);
        end else begin
          frameExp_t e;
          e = expQ.pop_front();
          check((negIdx - lastIdx) == e.len, e.tag, "frame length", negIdx - lastIdx, e.len);
          if (e.ticks >= 0)
            check(tickCnt == e.ticks, e.tag, "ticks per frame", tickCnt, e.ticks);
          check(syncErr == e.err, "R10", "syncErr at boundary", int'(syncErr), int'(e.err));
        end
        lastIdx = negIdx;
        tickCnt = 0;
      end else if (syncErr) begin
        check(1'b0, "R10", "syncErr off boundary", 1, 0);
      end
      if (frameSync != (tickCnt == 0))
        check(1'b0, "R6", "frameSync", int'(frameSync), int'(tickCnt == 0));
      if (oclkTick) tickCnt++;
    end
  end

  // R8: host frame sync wiggles while the block is frame master
  initial begin
    wait (toggleOn);
    while (toggleOn) begin
      repeat (7) @(negedge clk);
      if (toggleOn) extFs = ~extFs;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired, %0d frames outstanding", expQ.size());
    finishRun();
  end

  initial begin
    setCfg(1'b0, 2, 3, 0);
    toggleOn = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sampleStrobe == 1'b0, "R1", "strobe in reset", int'(sampleStrobe), 0);
    check(syncErr == 1'b0, "R1", "syncErr in reset", int'(syncErr), 0);
    check(frameSync == 1'b1, "R1", "frameSync in reset", int'(frameSync), 1);

    pushFrame(160, 160, 1'b0, "R1");
    pushFrame(384, 64, 1'b0, "R8");
    pushFrame(384, 64, 1'b0, "R7");
    pushFrame(192, 192, 1'b0, "R3");
    pushFrame(192, 192, 1'b0, "R3");
    pushFrame(480, 96, 1'b0, "R2");
    pushFrame(480, 96, 1'b0, "R2");
    pushFrame(160, 160, 1'b0, "R4");
    pushFrame(160, 160, 1'b0, "R4");
    pushFrame(384, 128, 1'b0, "R5");
    pushFrame(51, -1, 1'b0, "R9");
    pushFrame(128, 64, 1'b0, "R10");
    pushFrame(130, 65, 1'b1, "R10");
    pushFrame(128, 64, 1'b0, "R9");
    pushFrame(126, 63, 1'b1, "R10");
    pushFrame(128, 64, 1'b0, "R10");

    @(posedge clk);
    #1 rst = 1'b0;
    running = 1'b1;

    repeat (2) waitStrobe();
    setCfg(1'b1, 2, 3, 4);
    repeat (2) waitStrobe();
    setCfg(1'b0, 0, 5, 1);
    repeat (2) waitStrobe();
    setCfg(1'b0, 1, 1, 7);
    repeat (2) waitStrobe();
    toggleOn = 1'b0;
    setCfg(1'b0, 3, 1, 2);
    repeat (2) waitStrobe();

    slaveMode = 1'b1;
    extFs = 1'b1;
    setCfg(1'b0, 2, 1, 0);
    repeat (50) @(negedge clk);
    extFs = 1'b0;
    slaveFrame(128);
    slaveFrame(130);
    slaveFrame(128);
    slaveFrame(126);
    slaveFrame(128);

    wait (expQ.size() == 0);
    repeat (5) @(negedge clk);
    done = 1'b1;
    finishRun();
  end
endmodule